// File: doc/BRIEF.md
# Decode Template Slot Allocator

This block sits between an instruction queue and a bank of four parallel decoders. Each cycle the queue offers up to four instructions whose boundaries are already known. For each one it gives a valid bit and the number of micro-ops that instruction expands into. The allocator picks the longest program-order prefix that fits an asymmetric template. The lead slot takes an instruction worth up to four micro-ops. The three trailing slots take only single-micro-op instructions.

The first trailing instruction that needs more than one micro-op closes the group. It is offered again next cycle, when it becomes the lead. An instruction worth more than four micro-ops is not given to the simple decoders. It raises a request to a microcode sequencer, is consumed alone, and holds the allocator stalled until the sequencer reports completion.

Each cycle the block reports how many instructions it consumed, so the queue can advance by that amount. All allocation outputs are combinational from the queue inputs and a one-bit sequencer state.

Top module: `decode_slot_alloc`

## Requirements
- R1: When queue lane 0 is valid and needs 1 to 4 micro-ops (a count field of 0 counts as 1), slot 0 is valid and reports that count.
- R2: Slots 1 to 3 only ever carry an instruction needing exactly one micro-op, and they then report a count of 1.
- R3: Slots fill strictly in program order. The first lane after lane 0 that needs more than one micro-op ends the group, and no later lane is taken in that cycle, even if it is simple.
- R4: The group also ends at the first invalid lane. Every slot beyond the group shows valid 0, index 0 and micro-op count 0.
- R5: When lane 0 is valid and needs more than 4 micro-ops, and the block is not stalled, the sequencer request is 1 and carries the count. The consumed count is 1 and no slot is valid.
- R6: From the cycle after a sequencer request until the cycle after the done input is seen high, stall is 1, the consumed count is 0, no slot is valid and no new request is raised. Allocation resumes in the cycle after done.
- R7: The consumed count equals the number of valid slots, except in a request cycle, where it is 1.
- R8: After reset the block is not stalled and allocates from the first cycle.
- R9: A valid slot k reports index k, which is the queue lane it was taken from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 4 | Valid bit per queue lane, lane 0 oldest |
| in_uops | input | 16 | Micro-op count per lane, 4 bits each, lane k at bits 4k+3:4k |
| seq_done | input | 1 | Sequencer finished the long instruction |
| slot_vld | output | 4 | Valid per decode slot |
| slot_idx | output | 8 | Queue lane index per slot, 2 bits each |
| slot_uops | output | 12 | Micro-op count per slot, 3 bits each |
| take_cnt | output | 3 | Instructions consumed this cycle |
| ucode_req | output | 1 | Request to the microcode sequencer |
| ucode_uops | output | 4 | Micro-op count sent with the request, else 0 |
| stall | output | 1 | Waiting for the sequencer |

## Verification
A wrong group boundary shows up in the same cycle as a consumed count that differs from the prefix rule. Left alone, it would make the queue skip or repeat instructions. A sequencer state that is stuck or wrong shows up one cycle after a request or after done. It appears as stall, the consumed count and the slot valids all holding the wrong values for as long as the state stays wrong. The sweep covers every valid mask against a set of micro-op counts on each side of the 1 and 4 thresholds, so each template boundary is crossed in every lane.

// File: rtl/dtsa_pkg.sv
package dtsa_pkg;
  localparam int LANES     = 4;
  localparam int UOPW      = 4;
  localparam int LEAD_MAX  = 4;
  localparam int IDXW      = $clog2(LANES);
  localparam int SUW       = $clog2(LEAD_MAX + 1);
  localparam int CNTW      = $clog2(LANES + 1);

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_BUSY = 1'b1} seq_state_e;

  // A zero count field is treated as a single micro-op.
  function automatic logic [UOPW-1:0] eff_uops(input logic [UOPW-1:0] raw);
    return (raw == '0) ? UOPW'(1) : raw;
  endfunction

  function automatic logic fits_lead(input logic [UOPW-1:0] raw);
    return eff_uops(raw) <= UOPW'(LEAD_MAX);
  endfunction

  function automatic logic fits_follow(input logic [UOPW-1:0] raw);
    return eff_uops(raw) == UOPW'(1);
  endfunction
endpackage

// File: rtl/dtsa_lane_class.sv
module dtsa_lane_class
  import dtsa_pkg::*;
(
  input  logic [UOPW-1:0] raw_uops,
  output logic            lead_ok,
  output logic            follow_ok,
  output logic            is_long,
  output logic [UOPW-1:0] norm_uops
);
  always_comb begin
    norm_uops = eff_uops(raw_uops);
    lead_ok   = fits_lead(raw_uops);
    follow_ok = fits_follow(raw_uops);
    is_long   = !lead_ok;
  end
endmodule

// File: rtl/dtsa_group_form.sv
module dtsa_group_form
  import dtsa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [LANES-1:0]     vld,
  input  logic [LANES-1:0]     lead_ok,
  input  logic [LANES-1:0]     follow_ok,
  input  logic [LANES*UOPW-1:0] norm_uops,
  output logic [LANES-1:0]     sel,
  output logic [CNTW-1:0]      grp_cnt,
  output logic [LANES*IDXW-1:0] sel_idx,
  output logic [LANES*SUW-1:0] sel_uops
);
  always_comb begin
    logic run;
    run     = enable;
    grp_cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i == 0) run = run & vld[i] & lead_ok[i];
      else        run = run & vld[i] & follow_ok[i];
      sel[i]  = run;
      grp_cnt = grp_cnt + CNTW'(run);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_slot
    assign sel_idx[k*IDXW +: IDXW] = sel[k] ? IDXW'(k) : '0;
    assign sel_uops[k*SUW +: SUW]  = sel[k] ? norm_uops[k*UOPW +: SUW] : '0;

    if (k > 0) begin : g_follow
      assert_follow_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel[k] |-> (sel_uops[k*SUW +: SUW] == SUW'(1)));
      assert_prefix_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel[k] |-> sel[k-1]);
    end
  end

  assert_lead_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel[0] |-> (sel_uops[SUW-1:0] != '0 && sel_uops[SUW-1:0] <= SUW'(LEAD_MAX)));
  assert_count_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == int'(grp_cnt));
  assert_disabled_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (sel == '0));
endmodule

// File: rtl/dtsa_seq_ctl.sv
module dtsa_seq_ctl
  import dtsa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic seq_done,
  output logic busy
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SEQ_IDLE: if (fire)     st_d = SEQ_BUSY;
      SEQ_BUSY: if (seq_done) st_d = SEQ_IDLE;
      default:                st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q == SEQ_BUSY);

  assert_fire_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> busy);
  assert_hold_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> busy);
  assert_release_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && seq_done) |=> !busy);
  assert_no_fire_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fire);
endmodule

// File: rtl/decode_slot_alloc.sv
module decode_slot_alloc
  import dtsa_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       in_vld,
  input  logic [LANES*UOPW-1:0]  in_uops,
  input  logic                   seq_done,
  output logic [LANES-1:0]       slot_vld,
  output logic [LANES*IDXW-1:0]  slot_idx,
  output logic [LANES*SUW-1:0]   slot_uops,
  output logic [CNTW-1:0]        take_cnt,
  output logic                   ucode_req,
  output logic [UOPW-1:0]        ucode_uops,
  output logic                   stall
);
  logic [LANES-1:0]      lead_ok, follow_ok, is_long;
  logic [LANES*UOPW-1:0] norm_uops;
  logic [CNTW-1:0]       grp_cnt;
  logic                  busy, ucode_fire;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    dtsa_lane_class u_cls (
      .raw_uops  (in_uops[k*UOPW +: UOPW]),
      .lead_ok   (lead_ok[k]),
      .follow_ok (follow_ok[k]),
      .is_long   (is_long[k]),
      .norm_uops (norm_uops[k*UOPW +: UOPW])
    );
  end

  assign ucode_fire = !busy && in_vld[0] && is_long[0];

  dtsa_group_form u_grp (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (!busy),
    .vld       (in_vld),
    .lead_ok   (lead_ok),
    .follow_ok (follow_ok),
    .norm_uops (norm_uops),
    .sel       (slot_vld),
    .grp_cnt   (grp_cnt),
    .sel_idx   (slot_idx),
    .sel_uops  (slot_uops)
  );

  dtsa_seq_ctl u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (ucode_fire),
    .seq_done (seq_done),
    .busy     (busy)
  );

  assign ucode_req  = ucode_fire;
  assign ucode_uops = ucode_fire ? norm_uops[UOPW-1:0] : '0;
  assign take_cnt   = ucode_fire ? CNTW'(1) : grp_cnt;
  assign stall      = busy;

  assert_req_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_req |-> (slot_vld == '0 && take_cnt == CNTW'(1) && ucode_uops > UOPW'(LEAD_MAX)));
  assert_stall_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (take_cnt == '0 && !ucode_req));
endmodule

// File: tb/decode_slot_alloc_tb_top.sv
module decode_slot_alloc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_vld = '0;
  logic [15:0] in_uops = '0;
  logic        seq_done = 1'b0;
  logic [3:0]  slot_vld;
  logic [7:0]  slot_idx;
  logic [11:0] slot_uops;
  logic [2:0]  take_cnt;
  logic        ucode_req;
  logic [3:0]  ucode_uops;
  logic        stall;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  decode_slot_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_uops(in_uops),
    .seq_done(seq_done), .slot_vld(slot_vld), .slot_idx(slot_idx),
    .slot_uops(slot_uops), .take_cnt(take_cnt), .ucode_req(ucode_req),
    .ucode_uops(ucode_uops), .stall(stall)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (vld=%b uops=%h)", req, act, exp, in_vld, in_uops);
    end
  endtask

  // Independent reference: walk lanes, stop at first misfit.
  task automatic check_vector();
    int e [4];
    int ev [4];
    int n;
    bit lng;
    for (int i = 0; i < 4; i++) begin
      e[i]  = (in_uops[i*4 +: 4] == 0) ? 1 : int'(in_uops[i*4 +: 4]);
      ev[i] = 0;
    end
    lng = in_vld[0] && e[0] > 4;
    n = 0;
    if (!lng) begin
      for (int i = 0; i < 4; i++) begin
        if (!in_vld[i]) break;
        if (i > 0 && e[i] != 1) break;
        ev[i] = 1;
        n++;
      end
    end
    check("R5 ucode_req", int'(ucode_req), int'(lng));
    check("R5 ucode_uops", int'(ucode_uops), lng ? e[0] : 0);
    check("R7 take_cnt", int'(take_cnt), lng ? 1 : n);
    check("R8 stall idle", int'(stall), 0);
    for (int i = 0; i < 4; i++) begin
      check(i == 0 ? "R1 slot_vld" : "R3 R4 slot_vld", int'(slot_vld[i]), ev[i]);
      check(i == 0 ? "R1 slot_uops" : "R2 slot_uops", int'(slot_uops[i*3 +: 3]), ev[i] ? e[i] : 0);
      check("R9 slot_idx", int'(slot_idx[i*2 +: 2]), ev[i] ? i : 0);
    end
  endtask

  task automatic check_stalled(input string req);
    check({req, " stall"}, int'(stall), 1);
    check({req, " take_cnt"}, int'(take_cnt), 0);
    check({req, " slot_vld"}, int'(slot_vld), 0);
    check({req, " ucode_req"}, int'(ucode_req), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done_flag) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int vals [6] = '{0, 1, 2, 4, 5, 15};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset stall", int'(stall), 0);
    check("R8 reset take", int'(take_cnt), 0);

    for (int v = 0; v < 16; v++)
      for (int a = 0; a < 6; a++)
        for (int b = 0; b < 6; b++)
          for (int c = 0; c < 6; c++)
            for (int d = 0; d < 6; d++) begin
              @(posedge clk); #1;
              in_vld  = 4'(v);
              in_uops = {4'(vals[d]), 4'(vals[c]), 4'(vals[b]), 4'(vals[a])};
              @(negedge clk);
              check_vector();
              if (ucode_req) begin
                // R6: stalled with the same long instruction still offered
                repeat (2) begin
                  @(posedge clk); #1;
                  @(negedge clk);
                  check_stalled("R6 wait");
                end
                @(posedge clk); #1 seq_done = 1'b1;
                @(negedge clk);
                check_stalled("R6 done cycle");
                @(posedge clk); #1 seq_done = 1'b0;
                in_vld = 4'b0011;
                in_uops = 16'h0011;
                @(negedge clk);
                check("R6 resume stall", int'(stall), 0);
                check("R6 resume take", int'(take_cnt), 2);
              end
            end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule